// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code

This block compares two IEEE-754 operands of the same precision, either both single or both double, and writes a two-bit floating-point condition code. The code has four outcomes: equal, less, greater and unordered. One input bit picks between a quiet compare and a signalling compare. The two differ only in which NaN inputs raise the invalid-operation flag.

The compare is issued with a one-cycle strobe. When the floating-point unit is enabled, the code register is updated one cycle later and its write-enable pulses for that cycle. When the unit is disabled, the compare does not happen. The code is left untouched and a disabled-unit trap pulses instead. The code register is the only condition-code register this block writes.

Top module: `fp_compare_cc`

## Requirements
- R1: After reset, `cc` is 0 and `cc_we`, `invalid_exc` and `fpu_dis_trap` are all 0.
- R2: A strobe with `fpu_on` high makes `cc_we` 1 in the following cycle only. `cc` then holds the result, encoded as 0 = equal, 1 = less (a < b), 2 = greater (a > b), 3 = unordered.
- R3: For ordered operands the code follows numeric order across signs, including negative pairs and infinities, and +0 compares equal to −0.
- R4: When either operand is a NaN (exponent all ones, fraction non-zero), the code is 3.
- R5: With `signal_mode` = 0 (quiet), `invalid_exc` is 1 only when an operand is a signalling NaN (fraction MSB 0). A quiet NaN (fraction MSB 1) still gives code 3 with `invalid_exc` = 0.
- R6: With `signal_mode` = 1 (signalling), `invalid_exc` is 1 whenever either operand is any NaN.
- R7: With `prec_dbl` = 0, only bits [31:0] of each operand are compared as single precision and bits [63:32] have no effect. With `prec_dbl` = 1, all 64 bits are compared as double precision.
- R8: A strobe with `fpu_on` low makes `fpu_dis_trap` 1 in the following cycle only. `cc_we` and `invalid_exc` stay 0 and `cc` keeps its previous value.
- R9: In a cycle after which no strobe came, `cc_we`, `invalid_exc` and `fpu_dis_trap` are 0 and `cc` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle compare strobe |
| fpu_on | input | 1 | Unit present and enabled |
| prec_dbl | input | 1 | 0 = single, 1 = double precision |
| signal_mode | input | 1 | 0 = quiet compare, 1 = signalling compare |
| op_a | input | 64 | First operand (single uses [31:0]) |
| op_b | input | 64 | Second operand (single uses [31:0]) |
| cc | output | 2 | Condition code register |
| cc_we | output | 1 | Pulses when `cc` is written |
| invalid_exc | output | 1 | Invalid-operation flag for the compare |
| fpu_dis_trap | output | 1 | Pulses when a compare is refused |

## Verification
The hardest case to reach from the ports is an upper operand half that decides the answer in one precision and must be ignored in the other. The stimulus sends the same pair of 64-bit words twice. The upper half of one word is all ones, which is a NaN in double precision but meaningless in single precision. The expected code therefore moves from less to unordered. A compare refused by the disabled unit is placed between two valid compares, so that the held code can be seen at the ports.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   typedef enum logic [1:0] {
      CC_EQ = 2'd0,
      CC_LT = 2'd1,
      CC_GT = 2'd2,
      CC_UN = 2'd3
   } cc_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] value,
   output logic                 is_nan,
   output logic                 is_snan,
   output logic                 is_zero
);
   localparam int TOP = EXP_W + MAN_W;

   if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
      $error("fpc_classify: exponent and fraction need at least 2 bits");
   end

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;

   assign expo = value[TOP-1:MAN_W];
   assign frac = value[MAN_W-1:0];

   always_comb begin
      is_nan  = (&expo) && (|frac);
      is_snan = is_nan && !frac[MAN_W-1];
      is_zero = (expo == '0) && (frac == '0);
   end
endmodule

// File: rtl/fpc_order.sv
module fpc_order #(
   parameter int W = 32
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           a_nan,
   input  logic           b_nan,
   input  logic           a_zero,
   input  logic           b_zero,
   output fpc_pkg::cc_t   code
);
   import fpc_pkg::*;

   logic mag_lt;
   assign mag_lt = a[W-2:0] < b[W-2:0];

   always_comb begin
      if (a_nan || b_nan)
         code = CC_UN;
      else if ((a_zero && b_zero) || (a == b))
         code = CC_EQ;
      else if (a[W-1] != b[W-1])
         code = a[W-1] ? CC_LT : CC_GT;
      else if (!a[W-1])
         code = mag_lt ? CC_LT : CC_GT;
      else
         code = mag_lt ? CC_GT : CC_LT;
   end
endmodule

// File: rtl/fp_compare_cc.sv
module fp_compare_cc #(
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        fpu_on,
   input  logic        prec_dbl,
   input  logic        signal_mode,
   input  logic [63:0] op_a,
   input  logic [63:0] op_b,
   output logic [1:0]  cc,
   output logic        cc_we,
   output logic        invalid_exc,
   output logic        fpu_dis_trap
);
   import fpc_pkg::*;

   localparam int SP_W   = 1 + SP_EXP + SP_MAN;
   localparam int DP_W   = 1 + DP_EXP + DP_MAN;
   localparam int N_PREC = 2;

   if (DP_W != 64) begin : g_bad_dp
      $error("fp_compare_cc: double format must span 64 bits");
   end
   if (SP_W > DP_W) begin : g_bad_sp
      $error("fp_compare_cc: single format wider than double");
   end

   cc_t  code_p [N_PREC];
   logic nan_p  [N_PREC];
   logic snan_p [N_PREC];

   for (genvar p = 0; p < N_PREC; p++) begin : g_prec
      localparam int EW = (p == 0) ? SP_EXP : DP_EXP;
      localparam int MW = (p == 0) ? SP_MAN : DP_MAN;
      localparam int W  = 1 + EW + MW;

      logic a_nan, a_snan, a_zero;
      logic b_nan, b_snan, b_zero;

      fpc_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_a (
         .value(op_a[W-1:0]), .is_nan(a_nan), .is_snan(a_snan), .is_zero(a_zero));
      fpc_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_b (
         .value(op_b[W-1:0]), .is_nan(b_nan), .is_snan(b_snan), .is_zero(b_zero));

      fpc_order #(.W(W)) u_ord (
         .a(op_a[W-1:0]), .b(op_b[W-1:0]),
         .a_nan(a_nan), .b_nan(b_nan),
         .a_zero(a_zero), .b_zero(b_zero),
         .code(code_p[p]));

      assign nan_p[p]  = a_nan || b_nan;
      assign snan_p[p] = a_snan || b_snan;
   end

   cc_t  sel_code;
   logic sel_inv;
   logic accept;

   always_comb begin
      sel_code = prec_dbl ? code_p[1] : code_p[0];
      if (signal_mode)
         sel_inv = prec_dbl ? nan_p[1] : nan_p[0];
      else
         sel_inv = prec_dbl ? snan_p[1] : snan_p[0];
   end

   assign accept = req_valid && fpu_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cc           <= CC_EQ;
         cc_we        <= 1'b0;
         invalid_exc  <= 1'b0;
         fpu_dis_trap <= 1'b0;
      end else begin
         cc_we        <= accept;
         invalid_exc  <= accept && sel_inv;
         fpu_dis_trap <= req_valid && !fpu_on;
         if (accept)
            cc <= sel_code;
      end
   end

   // R2: a write only follows an accepted strobe
   a_r2_we_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cc_we |-> $past(req_valid && fpu_on));
   // R8: refused compare never writes the code
   a_r8_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(fpu_dis_trap && (cc_we || invalid_exc)));
   // R9: code unchanged without a write
   a_r9_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
      !cc_we |-> (cc == $past(cc)));
   // R5: an exception only accompanies an unordered result
   a_r5_exc_unordered: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_exc |-> (cc_we && cc == CC_UN));
   // R6: signalling compare flags every unordered result
   a_r6_sig_flags_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_we && cc == CC_UN && $past(signal_mode)) |-> invalid_exc);
endmodule

// File: tb/fp_compare_cc_test.sv
module fp_compare_cc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        fpu_on = 1'b1;
   logic        prec_dbl = 1'b0;
   logic        signal_mode = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [1:0]  cc;
   logic        cc_we, invalid_exc, fpu_dis_trap;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   fp_compare_cc uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fpu_on(fpu_on),
      .prec_dbl(prec_dbl), .signal_mode(signal_mode), .op_a(op_a), .op_b(op_b),
      .cc(cc), .cc_we(cc_we), .invalid_exc(invalid_exc), .fpu_dis_trap(fpu_dis_trap));

   task automatic check(string req, logic [3:0] got, logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // drive one strobe, sample one cycle after it
   task automatic cmp(string req, logic [63:0] a, logic [63:0] b, logic dbl,
                      logic sig, logic [1:0] exp_cc, logic exp_inv);
      @(negedge clk);
      op_a = a; op_b = b; prec_dbl = dbl; signal_mode = sig;
      fpu_on = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " cc"}, {2'b0, cc}, {2'b0, exp_cc});
      check({req, " we"}, {3'b0, cc_we}, 4'd1);
      check({req, " inv"}, {3'b0, invalid_exc}, {3'b0, exp_inv});
      check({req, " trap"}, {3'b0, fpu_dis_trap}, 4'd0);
   endtask

   task automatic test_reset();
      check("R1 cc", {2'b0, cc}, 4'd0);
      check("R1 flags", {1'b0, cc_we, invalid_exc, fpu_dis_trap}, 4'd0);
   endtask

   task automatic test_order();
      cmp("R2 sp lt", 64'h3F800000, 64'h40000000, 0, 0, 2'd1, 0);
      cmp("R2 sp gt", 64'h40000000, 64'h3F800000, 0, 0, 2'd2, 0);
      cmp("R2 sp eq", 64'h3F800000, 64'h3F800000, 0, 0, 2'd0, 0);
      cmp("R3 zeros", 64'h00000000, 64'h80000000, 0, 0, 2'd0, 0);
      cmp("R3 neg pair", 64'hBF800000, 64'hC0000000, 0, 0, 2'd2, 0);
      cmp("R3 sign mix", 64'hBF800000, 64'h00000000, 0, 0, 2'd1, 0);
      cmp("R3 inf", 64'h7F800000, 64'hFF800000, 0, 0, 2'd2, 0);
      cmp("R3 dp lt", 64'hC000000000000000, 64'h3FF0000000000000, 1, 0, 2'd1, 0);
   endtask

   task automatic test_nan();
      cmp("R4 R5 qnan quiet", 64'h7FC00000, 64'h3F800000, 0, 0, 2'd3, 0);
      cmp("R5 snan quiet", 64'h3F800000, 64'h7F800001, 0, 0, 2'd3, 1);
      cmp("R6 qnan signal", 64'h7FC00000, 64'h3F800000, 0, 1, 2'd3, 1);
      cmp("R6 dp qnan signal", 64'h7FF8000000000000, 64'h0, 1, 1, 2'd3, 1);
      cmp("R5 dp qnan quiet", 64'h7FF8000000000000, 64'h0, 1, 0, 2'd3, 0);
      cmp("R5 dp snan quiet", 64'h0, 64'h7FF0000000000001, 1, 0, 2'd3, 1);
      cmp("R6 signal ordered", 64'h40000000, 64'h40000000, 0, 1, 2'd0, 0);
   endtask

   task automatic test_precision();
      cmp("R7 sp ignores upper", 64'hFFFFFFFF_3F800000, 64'h00000000_40000000, 0, 0, 2'd1, 0);
      cmp("R7 dp uses upper", 64'hFFFFFFFF_3F800000, 64'h00000000_40000000, 1, 0, 2'd3, 0);
   endtask

   task automatic test_disabled();
      cmp("R8 setup", 64'h40000000, 64'h3F800000, 0, 0, 2'd2, 0);
      @(negedge clk);
      op_a = 64'h3F800000; op_b = 64'h40000000; fpu_on = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; fpu_on = 1'b1;
      check("R8 trap", {3'b0, fpu_dis_trap}, 4'd1);
      check("R8 no write", {2'b0, cc_we, invalid_exc}, 4'd0);
      check("R8 cc held", {2'b0, cc}, 4'd2);
      @(negedge clk);
      check("R9 idle flags", {1'b0, cc_we, invalid_exc, fpu_dis_trap}, 4'd0);
      check("R9 idle cc", {2'b0, cc}, 4'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_order();
      test_nan();
      test_precision();
      test_disabled();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule